// File: doc/BRIEF.md
# Lane latency monitor

This block sits on the link clock of a deterministic-latency serial receiver. It measures, separately for each lane, how long that lane needed to reach alignment. The measurement starts at the first local multiframe boundary after the link's synchronisation request is released. It stops on the cycle in which that lane leaves code-group synchronisation and begins its initial lane alignment sequence. The datapath carries four octets per link clock cycle, so the elapsed time advances by four octets each cycle. Each result is reported as a whole number of multiframes plus a remainder in octets.

The multiframe length in octets is the product of the configured octets per frame and frames per multiframe. Lanes are measured independently. When the request line is shared by several links, the measurement also includes the time spent waiting for the slowest link, because counting only begins once the line is actually released. Asserting the request again throws away every result and arms a fresh measurement. A lane that has not started alignment after 255 multiframes is flagged as saturated instead.

The results are not a stream. They are status values: each one is held until the next synchronisation request, so no back-pressure is involved and there is no ready input.

Top module: `lane_latency_mon`

## Requirements
- R1: After reset, every bit of lat_valid_o, lat_sat_o, lat_mf_o and lat_oct_o is zero.
- R2: Counting starts on the first cycle in which lmfc_pulse_i and sync_n_i are both high. That cycle counts as elapsed time zero, so a lane whose alignment pulse falls in that same cycle reports 0 multiframes and 0 octets.
- R3: Bit i of ila_start_i is a one-cycle pulse for lane i. When lane i pulses n cycles after the start cycle, the next cycle shows lat_valid_o[i]=1, lat_mf_o[i*8 +: 8] = (4n) / L and lat_oct_o[i*10 +: 10] = (4n) mod L, where L is the multiframe length in octets.
- R4: Each lane captures only its own first pulse. Later pulses on a lane that already has a result leave its value unchanged.
- R5: Alignment pulses that arrive while sync_n_i is low, or after release but before counting has started, are ignored. The lane stays unmeasured.
- R6: A cycle with sync_n_i low clears all valid flags, saturation flags and results by the next cycle. This holds even when an alignment pulse falls in the same cycle. The next release starts a fresh measurement.
- R7: L = cfg_octets_per_frame_i × cfg_frames_per_mf_i. L must be a multiple of 4, must not exceed 1020, and must stay constant while sync_n_i is high.
- R8: If the elapsed time reaches 255 multiframes with no pulse on a lane, that lane's lat_sat_o bit is set on the next cycle and its valid bit stays low. A pulse in that cycle or any later one is ignored.
- R9: Once counting has started, further boundary pulses neither restart nor disturb the count.
- R10: While sync_n_i stays high, a valid or saturation flag that has been set stays set, and its result stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n_i | input | 1 | Link synchronisation request, active low |
| lmfc_pulse_i | input | 1 | One-cycle pulse at each local multiframe boundary |
| ila_start_i | input | NUM_LANES | Per-lane pulse marking the move from code-group synchronisation to the alignment sequence |
| cfg_octets_per_frame_i | input | F_W | Octets per frame |
| cfg_frames_per_mf_i | input | K_W | Frames per multiframe |
| lat_mf_o | output | NUM_LANES*MF_W | Per-lane whole multiframes, lane i at bits [i*MF_W +: MF_W] |
| lat_oct_o | output | NUM_LANES*OCT_W | Per-lane octet remainder, lane i at bits [i*OCT_W +: OCT_W] |
| lat_valid_o | output | NUM_LANES | Lane result is held and valid |
| lat_sat_o | output | NUM_LANES | Lane did not align within 255 multiframes |

## Verification
Two situations put two functions of the block into the same cycle. In the first, the boundary pulse that starts counting coincides with a lane's alignment pulse. The bench waits until its own boundary generator is about to fire and drives the lane pulse together with it; a zero result is expected. In the second, a renewed synchronisation request coincides with an alignment pulse, and the clear must win. The same reasoning applies where saturation meets a late pulse. A behavioural reference model built from integers and division, sampled every cycle, judges each of these cases against the outputs.

// File: rtl/lat_mon_pkg.sv
package lat_mon_pkg;
  // Link-level measurement phase
  typedef enum logic [1:0] {
    PH_HELD  = 2'd0,  // request asserted, nothing counts
    PH_ARMED = 2'd1,  // released, waiting for a multiframe boundary
    PH_COUNT = 2'd2   // elapsed time is advancing
  } link_phase_e;
endpackage

// File: rtl/lat_mf_timer.sv
module lat_mf_timer
  import lat_mon_pkg::*;
#(
  parameter int unsigned MF_W  = 8,
  parameter int unsigned OCT_W = 10,
  parameter int unsigned LEN_W = 14,
  parameter int unsigned BEAT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  input  logic             lmfc_pulse,
  input  logic [LEN_W-1:0] mf_len,
  output logic             counting,
  output logic             sat_hit,
  output logic [MF_W-1:0]  mf_cnt,
  output logic [OCT_W-1:0] oct_cnt
);
  localparam logic [MF_W-1:0] MF_MAX = '1;

  link_phase_e      phase_q, phase_d;
  logic [MF_W-1:0]  mf_q, mf_d;
  logic [OCT_W-1:0] oct_q, oct_d;
  logic [LEN_W-1:0] oct_sum;
  logic             start;

  always_comb begin
    start    = sync_n && lmfc_pulse && (phase_q != PH_COUNT);
    counting = sync_n && ((phase_q == PH_COUNT) || start);
    sat_hit  = counting && (mf_q == MF_MAX);
    oct_sum  = LEN_W'(oct_q) + LEN_W'(BEAT);
    phase_d  = phase_q;
    mf_d     = mf_q;
    oct_d    = oct_q;
    if (!sync_n) begin
      phase_d = PH_HELD;
      mf_d    = '0;
      oct_d   = '0;
    end else if (counting) begin
      phase_d = PH_COUNT;
      if (!sat_hit) begin
        if (oct_sum >= mf_len) begin
          oct_d = '0;
          mf_d  = mf_q + 1'b1;
        end else begin
          oct_d = OCT_W'(oct_sum);
        end
      end
    end else begin
      phase_d = PH_ARMED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HELD;
      mf_q    <= '0;
      oct_q   <= '0;
    end else begin
      phase_q <= phase_d;
      mf_q    <= mf_d;
      oct_q   <= oct_d;
    end
  end

  assign mf_cnt  = mf_q;
  assign oct_cnt = oct_q;
endmodule

// File: rtl/lat_lane_cap.sv
module lat_lane_cap #(
  parameter int unsigned MF_W  = 8,
  parameter int unsigned OCT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  input  logic             counting,
  input  logic             sat_hit,
  input  logic             ila,
  input  logic [MF_W-1:0]  mf_in,
  input  logic [OCT_W-1:0] oct_in,
  output logic             valid,
  output logic             sat,
  output logic [MF_W-1:0]  mf_out,
  output logic [OCT_W-1:0] oct_out
);
  logic pending;
  assign pending = counting && !valid && !sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      sat     <= 1'b0;
      mf_out  <= '0;
      oct_out <= '0;
    end else if (!sync_n) begin
      valid   <= 1'b0;
      sat     <= 1'b0;
      mf_out  <= '0;
      oct_out <= '0;
    end else if (pending) begin
      if (sat_hit) begin
        sat <= 1'b1;
      end else if (ila) begin
        valid   <= 1'b1;
        mf_out  <= mf_in;
        oct_out <= oct_in;
      end
    end
  end
endmodule

// File: rtl/lane_latency_mon.sv
module lane_latency_mon #(
  parameter int unsigned NUM_LANES = 2,
  parameter int unsigned MF_W      = 8,
  parameter int unsigned OCT_W     = 10,
  parameter int unsigned BEAT      = 4,
  parameter int unsigned F_W       = 8,
  parameter int unsigned K_W       = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sync_n_i,
  input  logic                       lmfc_pulse_i,
  input  logic [NUM_LANES-1:0]       ila_start_i,
  input  logic [F_W-1:0]             cfg_octets_per_frame_i,
  input  logic [K_W-1:0]             cfg_frames_per_mf_i,
  output logic [NUM_LANES*MF_W-1:0]  lat_mf_o,
  output logic [NUM_LANES*OCT_W-1:0] lat_oct_o,
  output logic [NUM_LANES-1:0]       lat_valid_o,
  output logic [NUM_LANES-1:0]       lat_sat_o
);
  localparam int unsigned LEN_W = F_W + K_W;

  logic [LEN_W-1:0] mf_len;
  logic             counting, sat_hit;
  logic [MF_W-1:0]  mf_cnt;
  logic [OCT_W-1:0] oct_cnt;

  assign mf_len = LEN_W'(cfg_octets_per_frame_i) * LEN_W'(cfg_frames_per_mf_i);

  lat_mf_timer #(
    .MF_W (MF_W),
    .OCT_W(OCT_W),
    .LEN_W(LEN_W),
    .BEAT (BEAT)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_n    (sync_n_i),
    .lmfc_pulse(lmfc_pulse_i),
    .mf_len    (mf_len),
    .counting  (counting),
    .sat_hit   (sat_hit),
    .mf_cnt    (mf_cnt),
    .oct_cnt   (oct_cnt)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lat_lane_cap #(
      .MF_W (MF_W),
      .OCT_W(OCT_W)
    ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_n  (sync_n_i),
      .counting(counting),
      .sat_hit (sat_hit),
      .ila     (ila_start_i[g]),
      .mf_in   (mf_cnt),
      .oct_in  (oct_cnt),
      .valid   (lat_valid_o[g]),
      .sat     (lat_sat_o[g]),
      .mf_out  (lat_mf_o[g*MF_W +: MF_W]),
      .oct_out (lat_oct_o[g*OCT_W +: OCT_W])
    );
  end
endmodule

// File: rtl/lane_latency_mon_chk.sv
module lane_latency_mon_chk #(
  parameter int unsigned NUM_LANES = 2,
  parameter int unsigned MF_W      = 8,
  parameter int unsigned OCT_W     = 10,
  parameter int unsigned BEAT      = 4,
  parameter int unsigned F_W       = 8,
  parameter int unsigned K_W       = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sync_n_i,
  input logic [NUM_LANES-1:0]       ila_start_i,
  input logic [F_W-1:0]             cfg_octets_per_frame_i,
  input logic [K_W-1:0]             cfg_frames_per_mf_i,
  input logic [NUM_LANES*MF_W-1:0]  lat_mf_o,
  input logic [NUM_LANES*OCT_W-1:0] lat_oct_o,
  input logic [NUM_LANES-1:0]       lat_valid_o,
  input logic [NUM_LANES-1:0]       lat_sat_o
);
  localparam int unsigned LEN_W = F_W + K_W;
  logic [LEN_W-1:0] len_ref;
  assign len_ref = LEN_W'(cfg_octets_per_frame_i) * LEN_W'(cfg_frames_per_mf_i);

  // R6
  clear_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_i |=> (lat_valid_o == '0) && (lat_sat_o == '0));

  // R10
  valid_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n_i |=> ((lat_valid_o & $past(lat_valid_o)) == $past(lat_valid_o)));

  // R10
  sat_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n_i |=> ((lat_sat_o & $past(lat_sat_o)) == $past(lat_sat_o)));

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
    // R3
    rise_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lat_valid_o[g]) |-> $past(ila_start_i[g]));

    // R5
    rise_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lat_valid_o[g]) |-> $past(sync_n_i));

    // R3
    remainder_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lat_valid_o[g] |-> ((LEN_W'(lat_oct_o[g*OCT_W +: OCT_W]) < len_ref) &&
                          ((lat_oct_o[g*OCT_W +: OCT_W] % BEAT) == 0)));

    // R10
    value_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_n_i && lat_valid_o[g]) |=> $stable(lat_mf_o[g*MF_W +: MF_W]) &&
                                      $stable(lat_oct_o[g*OCT_W +: OCT_W]));

    // R8
    sat_excludes_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lat_sat_o[g] |-> !lat_valid_o[g]);
  end
endmodule

bind lane_latency_mon lane_latency_mon_chk #(
  .NUM_LANES(NUM_LANES),
  .MF_W     (MF_W),
  .OCT_W    (OCT_W),
  .BEAT     (BEAT),
  .F_W      (F_W),
  .K_W      (K_W)
) u_chk (
  .clk                   (clk),
  .rst_n                 (rst_n),
  .sync_n_i              (sync_n_i),
  .ila_start_i           (ila_start_i),
  .cfg_octets_per_frame_i(cfg_octets_per_frame_i),
  .cfg_frames_per_mf_i   (cfg_frames_per_mf_i),
  .lat_mf_o              (lat_mf_o),
  .lat_oct_o             (lat_oct_o),
  .lat_valid_o           (lat_valid_o),
  .lat_sat_o             (lat_sat_o)
);

// File: tb/tb_lane_latency_mon.sv
`timescale 1ns/1ps
module tb_lane_latency_mon;
  localparam int NL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_n = 1'b0;
  logic        lmfc = 1'b0;
  logic [1:0]  ila = 2'b00;
  logic [7:0]  cfg_f = 8'd4;
  logic [5:0]  cfg_k = 6'd32;
  logic [15:0] mf_o;
  logic [19:0] oct_o;
  logic [1:0]  valid_o, sat_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // stimulus staging
  logic       nx_sync = 1'b0;
  logic [1:0] nx_ila = 2'b00;
  int         lphase = 0;
  int         lper = 32;

  always #2.5 clk = ~clk;

  lane_latency_mon dut (
    .clk                   (clk),
    .rst_n                 (rst_n),
    .sync_n_i              (sync_n),
    .lmfc_pulse_i          (lmfc),
    .ila_start_i           (ila),
    .cfg_octets_per_frame_i(cfg_f),
    .cfg_frames_per_mf_i   (cfg_k),
    .lat_mf_o              (mf_o),
    .lat_oct_o             (oct_o),
    .lat_valid_o           (valid_o),
    .lat_sat_o             (sat_o)
  );

  // behavioural reference model
  bit m_run = 0;
  int m_cyc = 0;
  bit m_valid [NL];
  bit m_sat   [NL];
  int m_mf    [NL];
  int m_oct   [NL];
  int e_cyc, e_oct, e_len, e_mf, e_rem;
  bit e_sat;

  task automatic model_clear();
    m_run = 0;
    m_cyc = 0;
    for (int i = 0; i < NL; i++) begin
      m_valid[i] = 0; m_sat[i] = 0; m_mf[i] = 0; m_oct[i] = 0;
    end
  endtask

  initial model_clear();

  always @(posedge clk) begin
    if (!rst_n || !sync_n) begin
      model_clear();
    end else if (m_run || lmfc) begin
      e_cyc = m_run ? m_cyc : 0;
      e_len = int'(cfg_f) * int'(cfg_k);
      e_oct = e_cyc * 4;
      e_mf  = e_oct / e_len;
      e_rem = e_oct % e_len;
      e_sat = (e_mf >= 255);
      for (int i = 0; i < NL; i++) begin
        if (!m_valid[i] && !m_sat[i]) begin
          if (e_sat) m_sat[i] = 1;
          else if (ila[i]) begin
            m_valid[i] = 1; m_mf[i] = e_mf; m_oct[i] = e_rem;
          end
        end
      end
      m_run = 1;
      if (!e_sat) m_cyc = e_cyc + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < NL; i++) begin
      check(valid_o[i] == m_valid[i], cur_req, $sformatf("lane%0d valid", i), valid_o[i], m_valid[i]);
      check(sat_o[i] == m_sat[i], cur_req, $sformatf("lane%0d sat", i), sat_o[i], m_sat[i]);
      if (m_valid[i]) begin
        check(int'(mf_o[i*8 +: 8]) == m_mf[i], cur_req, $sformatf("lane%0d mf", i), mf_o[i*8 +: 8], m_mf[i]);
        check(int'(oct_o[i*10 +: 10]) == m_oct[i], cur_req, $sformatf("lane%0d oct", i), oct_o[i*10 +: 10], m_oct[i]);
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    sync_n = nx_sync;
    ila    = nx_ila;
    lmfc   = (lphase == 0);
    lphase = (lphase + 1) % lper;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse(input logic [1:0] m);
    nx_ila = m;
    tick();
    nx_ila = 2'b00;
  endtask

  task automatic hold_request(input int f, input int k);
    nx_sync = 1'b0;
    ticks(3);
    cfg_f  = 8'(f);
    cfg_k  = 6'(k);
    lper   = f * k / 4;
    lphase = 1;
    ticks(2);
  endtask

  task automatic wait_phase(input int p);
    while (lphase != p) tick();
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    ticks(4);
    check(valid_o == 2'b00 && sat_o == 2'b00, "R1", "flags in reset", {sat_o, valid_o}, 0);
    check(mf_o == '0 && oct_o == '0, "R1", "results in reset", int'(mf_o), 0);
    rst_n = 1'b1;
    ticks(3);

    // R5: pulses while held and while waiting for a boundary
    cur_req = "R5";
    hold_request(4, 32);
    pulse(2'b11);
    wait_phase(3);
    nx_sync = 1'b1;
    tick();
    pulse(2'b11);
    ticks(2);
    check(valid_o == 2'b00, "R5", "early pulses ignored", valid_o, 0);

    // R2 R3 R9: normal measurement, lanes differ, boundaries keep coming
    cur_req = "R3";
    ticks(40);
    pulse(2'b01);
    cur_req = "R9";
    ticks(77);
    pulse(2'b10);
    ticks(3);
    // R4: second pulses ignored
    cur_req = "R4";
    pulse(2'b11);
    ticks(5);
    // R10: hold
    cur_req = "R10";
    ticks(40);

    // R6: clear with a coincident pulse
    cur_req = "R6";
    nx_sync = 1'b0;
    nx_ila  = 2'b11;
    tick();
    nx_ila = 2'b00;
    tick();
    check(valid_o == 2'b00, "R6", "cleared by request", valid_o, 0);
    ticks(4);

    // R2: start boundary and lane pulse coincide
    cur_req = "R2";
    wait_phase(5);
    nx_sync = 1'b1;
    tick();
    wait_phase(0);
    pulse(2'b01);
    tick();
    check(valid_o[0] == 1'b1, "R2", "coincident valid", valid_o[0], 1);
    check(mf_o[7:0] == 8'd0 && oct_o[9:0] == 10'd0, "R2", "coincident zero", int'(oct_o[9:0]), 0);
    ticks(9);
    pulse(2'b10);
    ticks(3);

    // R7: short multiframe
    cur_req = "R7";
    hold_request(2, 4);
    nx_sync = 1'b1;
    ticks(7);
    pulse(2'b10);
    ticks(12);
    pulse(2'b01);
    ticks(3);

    // R7: length 20 octets
    hold_request(1, 20);
    nx_sync = 1'b1;
    ticks(9);
    pulse(2'b01);
    ticks(23);
    pulse(2'b10);
    ticks(3);

    // R8: saturation on lane 1, lane 0 measured earlier
    cur_req = "R8";
    hold_request(2, 4);
    nx_sync = 1'b1;
    ticks(30);
    pulse(2'b01);
    ticks(520);
    check(sat_o == 2'b10, "R8", "saturation flags", sat_o, 2);
    pulse(2'b10);
    ticks(3);
    check(valid_o == 2'b01, "R8", "late pulse ignored", valid_o, 1);

    // R6: fresh measurement after saturation
    cur_req = "R6";
    hold_request(4, 32);
    nx_sync = 1'b1;
    ticks(50);
    pulse(2'b11);
    ticks(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule